// File: doc/BRIEF.md
# Saturating doubling multiply-accumulate unit

This block is a lane-parallel arithmetic datapath for a 128-bit vector of signed elements. In each lane it multiplies two element-sized operands and doubles the product. It then adds an accumulator operand that has been moved up by the element width, and can add a half-unit rounding constant. The sum is clamped to the signed range of a value twice the element width, and the upper element-width bits form the lane result. Elements may be 8, 16 or 32 bits wide.

A mode input chooses where the operands come from. In one arrangement the second multiplier operand is a broadcast scalar and the accumulator is taken from the second vector. In the other arrangement both multiplier operands come from the vectors and the scalar is the accumulator. A per-byte enable mask decides which result bytes are written. The result is registered with one cycle of latency and a valid strobe. A sticky flag records any saturation in an enabled lane until software-driven logic clears it.

Top module: `sqdmla_unit`

## Requirements
- R1: For element width E, with x and y the multiplier operands and c the accumulator (all signed E-bit), each lane returns bits [2E-1:E] of 2·x·y + c·2^E (+ rounding) when that sum lies inside the signed 2E-bit range.
- R2: When the sum exceeds 2^(2E-1)-1 the lane returns the largest positive E-bit value (0x7F.., sign bit 0). When the sum is below -2^(2E-1) it returns the most negative value (0x80.., sign bit 1).
- R3: With mode=0, x is lane i of vec_a, y is the low E bits of scalar, and c is lane i of vec_b.
- R4: With mode=1, x is lane i of vec_a, y is lane i of vec_b, and c is the low E bits of scalar.
- R5: size_code 0 selects E=8, 1 selects E=16, and 2 and 3 both select E=32. Lane i occupies bits [i·E+E-1 : i·E] of every vector.
- R6: With round_en=1 the constant 2^(E-1) is added to the sum before saturation. With round_en=0 nothing is added.
- R7: byte_en bit j governs result bits [8j+7:8j]. When the bit is clear, that byte keeps its previous output value.
- R8: result and out_valid update on the clock edge after in_valid is sampled high. When in_valid is low, result holds and out_valid is 0 in the next cycle.
- R9: sat_flag becomes 1 after an accepted operation in which a lane with at least one enabled byte saturates. Lanes with no enabled bytes never set it.
- R10: sat_flag stays set until sat_clr is sampled high. A saturation accepted in the same cycle as sat_clr leaves the flag set.
- R11: After reset, result is 0, out_valid is 0 and sat_flag is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation accepted this cycle |
| size_code | input | 2 | Element width select (0:8, 1:16, 2/3:32) |
| mode | input | 1 | 0: vector×scalar + vector, 1: vector×vector + scalar |
| round_en | input | 1 | Add half-unit rounding constant |
| byte_en | input | 16 | Per-byte write enable of the result |
| vec_a | input | 128 | First vector operand |
| vec_b | input | 128 | Second vector operand |
| scalar | input | 32 | Scalar operand (low E bits used) |
| sat_clr | input | 1 | Clear the sticky saturation flag |
| out_valid | output | 1 | Result updated this cycle |
| result | output | 128 | Registered result vector |
| sat_flag | output | 1 | Sticky saturation indicator |

## Verification
Small operands in both modes at each width show whether the lane boundaries are right and whether the accumulator and the scalar are routed to the correct place. If they are swapped, mode 0 and mode 1 give different values. Operands at the extremes of the element range drive the sum past both limits, and toggling rounding on those inputs shows whether the half-unit constant is added before the clamp. Partial and empty byte masks combined with saturating data show whether merging happens per byte and whether masked lanes are kept out of the flag. A long run of random operands then covers every size code, including the duplicate 32-bit code.

// File: rtl/sqdmla_pkg.sv
package sqdmla_pkg;
   typedef enum logic [1:0] {
      SZ_B8    = 2'd0,
      SZ_H16   = 2'd1,
      SZ_W32   = 2'd2,
      SZ_W32B  = 2'd3
   } esize_e;

   localparam int NUM_SIZES = 3;

   function automatic int size_index(input logic [1:0] code);
      case (esize_e'(code))
         SZ_B8:   return 0;
         SZ_H16:  return 1;
         default: return 2;
      endcase
   endfunction
endpackage

// File: rtl/sqdmla_lane.sv
module sqdmla_lane #(
   parameter int E = 8
) (
   input  logic [E-1:0] op_x,
   input  logic [E-1:0] op_y,
   input  logic [E-1:0] acc,
   input  logic         rnd,
   output logic [E-1:0] res,
   output logic         sat
);
   localparam int W = 2*E + 3;
   localparam logic signed [W-1:0] RND_K = {{(W-E){1'b0}}, 1'b1, {(E-1){1'b0}}};
   localparam logic signed [W-1:0] HI_K  = {{(W-2*E+1){1'b0}}, {(2*E-1){1'b1}}};
   localparam logic signed [W-1:0] LO_K  = ~HI_K;

   initial begin
      if (E < 2) $error("lane width too small");
   end

   logic signed [W-1:0] xs, ys, cs, prod, sum;
   logic                over_hi, under_lo;

   always_comb begin
      xs       = {{(W-E){op_x[E-1]}}, op_x};
      ys       = {{(W-E){op_y[E-1]}}, op_y};
      cs       = {{(W-E){acc[E-1]}}, acc};
      prod     = xs * ys;
      sum      = (prod <<< 1) + (cs <<< E) + (rnd ? RND_K : '0);
      over_hi  = sum > HI_K;
      under_lo = sum < LO_K;
      sat      = over_hi | under_lo;
      if (over_hi)       res = {1'b0, {(E-1){1'b1}}};
      else if (under_lo) res = {1'b1, {(E-1){1'b0}}};
      else               res = sum[2*E-1:E];
   end
endmodule

// File: rtl/sqdmla_slice.sv
module sqdmla_slice #(
   parameter int VEC_W = 128,
   parameter int E     = 8
) (
   input  logic [VEC_W-1:0]   va,
   input  logic [VEC_W-1:0]   vb,
   input  logic [E-1:0]       sc,
   input  logic               mode,
   input  logic               rnd,
   input  logic [VEC_W/8-1:0] be,
   output logic [VEC_W-1:0]   res,
   output logic               sat_any
);
   localparam int LANES = VEC_W / E;
   localparam int BPL   = E / 8;

   initial begin
      if (VEC_W % E != 0) $error("vector width not a multiple of lane width");
      if (E % 8 != 0)     $error("lane width must be whole bytes");
   end

   logic [LANES-1:0] lane_sat, lane_en;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [E-1:0] ea, eb, y_op, c_op;
      assign ea   = va[i*E +: E];
      assign eb   = vb[i*E +: E];
      assign y_op = mode ? eb : sc;
      assign c_op = mode ? sc : eb;
      assign lane_en[i] = |be[i*BPL +: BPL];

      sqdmla_lane #(.E(E)) u_lane (
         .op_x (ea),
         .op_y (y_op),
         .acc  (c_op),
         .rnd  (rnd),
         .res  (res[i*E +: E]),
         .sat  (lane_sat[i])
      );
   end

   assign sat_any = |(lane_sat & lane_en);
endmodule

// File: rtl/sqdmla_unit.sv
module sqdmla_unit
   import sqdmla_pkg::*;
#(
   parameter int VEC_W    = 128,
   parameter int SCALAR_W = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic [1:0]           size_code,
   input  logic                 mode,
   input  logic                 round_en,
   input  logic [VEC_W/8-1:0]   byte_en,
   input  logic [VEC_W-1:0]     vec_a,
   input  logic [VEC_W-1:0]     vec_b,
   input  logic [SCALAR_W-1:0]  scalar,
   input  logic                 sat_clr,
   output logic                 out_valid,
   output logic [VEC_W-1:0]     result,
   output logic                 sat_flag
);
   localparam int NB = VEC_W / 8;

   initial begin
      if (VEC_W % 32 != 0)  $error("VEC_W must be a multiple of 32");
      if (SCALAR_W != 32)   $error("SCALAR_W must equal the widest lane");
   end

   logic [VEC_W-1:0]     res_k [NUM_SIZES];
   logic [NUM_SIZES-1:0] sat_k;

   for (genvar k = 0; k < NUM_SIZES; k++) begin : g_size
      localparam int EK = 8 << k;
      sqdmla_slice #(.VEC_W(VEC_W), .E(EK)) u_slice (
         .va      (vec_a),
         .vb      (vec_b),
         .sc      (scalar[EK-1:0]),
         .mode    (mode),
         .rnd     (round_en),
         .be      (byte_en),
         .res     (res_k[k]),
         .sat_any (sat_k[k])
      );
   end

   logic [VEC_W-1:0] computed, merged;
   logic             sat_sel;

   always_comb begin
      computed = res_k[size_index(size_code)];
      sat_sel  = sat_k[size_index(size_code)];
      for (int j = 0; j < NB; j++)
         merged[j*8 +: 8] = byte_en[j] ? computed[j*8 +: 8] : result[j*8 +: 8];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
         sat_flag  <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) result <= merged;
         sat_flag  <= (sat_flag & ~sat_clr) | (in_valid & sat_sel);
      end
   end

   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);                                     // R8
   AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);                                   // R8
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(result));                              // R8
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (sat_flag && !sat_clr) |=> sat_flag);                        // R10
   AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (sat_clr && !in_valid) |=> !sat_flag);                       // R10
   AST_FLAG_NO_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (!sat_flag && (byte_en == '0 || !in_valid)) |=> !sat_flag);  // R9

   for (genvar j = 0; j < NB; j++) begin : g_chk
      AST_BYTE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && !byte_en[j]) |=> $stable(result[j*8 +: 8])); // R7
   end
endmodule

// File: tb/tb_sqdmla_unit.sv
module tb_sqdmla_unit;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [1:0]   size_code = 2'd0;
   logic         mode = 1'b0;
   logic         round_en = 1'b0;
   logic [15:0]  byte_en = '0;
   logic [127:0] vec_a = '0;
   logic [127:0] vec_b = '0;
   logic [31:0]  scalar = '0;
   logic         sat_clr = 1'b0;
   logic         out_valid;
   logic [127:0] result;
   logic         sat_flag;

   int errors = 0;
   int checks = 0;

   logic [127:0] m_res  = '0;
   logic         m_flag = 1'b0;

   always #2.5 clk = ~clk;

   sqdmla_unit dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .size_code(size_code),
      .mode(mode), .round_en(round_en), .byte_en(byte_en), .vec_a(vec_a),
      .vec_b(vec_b), .scalar(scalar), .sat_clr(sat_clr), .out_valid(out_valid),
      .result(result), .sat_flag(sat_flag)
   );

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not finish (got timeout, expected completion)");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // behavioural lane model in wide integer arithmetic
   function automatic logic [31:0] lane_model(input int e, input logic [31:0] x,
         input logic [31:0] y, input logic [31:0] c, input logic rnd, output logic s);
      logic signed [127:0] xx, yy, cc, t, hi, lo;
      xx = {96'd0, x}; yy = {96'd0, y}; cc = {96'd0, c};
      if (x[e-1]) xx = xx - (128'sd1 <<< e);
      if (y[e-1]) yy = yy - (128'sd1 <<< e);
      if (c[e-1]) cc = cc - (128'sd1 <<< e);
      t  = 2 * xx * yy + cc * (128'sd1 <<< e) + (rnd ? (128'sd1 <<< (e-1)) : 128'sd0);
      hi = (128'sd1 <<< (2*e-1)) - 1;
      lo = -hi - 1;
      s  = 1'b0;
      if (t > hi) begin s = 1'b1; t = hi; end
      else if (t < lo) begin s = 1'b1; t = lo; end
      return 32'((t >>> e) & ((128'sd1 <<< e) - 1));
   endfunction

   task automatic op(input string tag, input logic v, input logic [1:0] sz,
         input logic md, input logic rnd, input logic [15:0] be,
         input logic [127:0] a, input logic [127:0] b, input logic [31:0] sc,
         input logic clr);
      int e;
      logic [127:0] comp;
      logic any_sat;
      e = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
      comp = '0; any_sat = 1'b0;
      for (int i = 0; i < 128 / e; i++) begin
         logic [31:0] ea, eb, es, m, r;
         logic s, en;
         m  = (e == 32) ? 32'hFFFF_FFFF : ((32'd1 << e) - 1);
         ea = 32'(a >> (i*e)) & m;
         eb = 32'(b >> (i*e)) & m;
         es = sc & m;
         r  = md ? lane_model(e, ea, eb, es, rnd, s) : lane_model(e, ea, es, eb, rnd, s);
         comp = comp | (128'(r) << (i*e));
         en = 1'b0;
         for (int q = 0; q < e/8; q++) en = en | be[i*(e/8) + q];
         any_sat = any_sat | (s & en);
      end
      if (v)
         for (int j = 0; j < 16; j++)
            if (be[j]) m_res[j*8 +: 8] = comp[j*8 +: 8];
      m_flag = (m_flag & ~clr) | (v & any_sat);

      in_valid = v; size_code = sz; mode = md; round_en = rnd; byte_en = be;
      vec_a = a; vec_b = b; scalar = sc; sat_clr = clr;
      @(posedge clk); #1;
      chk({tag, " result"}, result, m_res);
      chk({tag, " out_valid (R8)"}, {127'd0, out_valid}, {127'd0, v});
      chk({tag, " sat_flag"}, {127'd0, sat_flag}, {127'd0, m_flag});
      @(negedge clk);
      in_valid = 1'b0; sat_clr = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R11 reset result", result, '0);
      chk("R11 reset out_valid", {127'd0, out_valid}, '0);
      chk("R11 reset sat_flag", {127'd0, sat_flag}, '0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 R3 R5: small values, mode 0, 8-bit lanes
      op("R3 m0 e8", 1, 2'd0, 0, 0, 16'hFFFF,
         128'h0102_0304_0506_0708_F9FA_FBFC_FDFE_FF00,
         128'h1122_3344_5566_7788_99AA_BBCC_DDEE_FF01, 32'h0000_0003, 0);
      // R6: rounding on same data
      op("R6 m0 e8 rnd", 1, 2'd0, 0, 1, 16'hFFFF,
         128'h0102_0304_0506_0708_F9FA_FBFC_FDFE_FF00,
         128'h1122_3344_5566_7788_99AA_BBCC_DDEE_FF01, 32'h0000_0003, 0);
      // R4 R5: mode 1, 16-bit lanes
      op("R4 m1 e16", 1, 2'd1, 1, 0, 16'hFFFF,
         128'h0010_FFF0_0100_8000_1234_0002_7FFF_0003,
         128'h0020_0030_FF00_0001_0010_FFFF_0001_0004, 32'h0000_ABCD, 0);
      // R1 R5: 32-bit lanes, both modes, size codes 2 and 3
      op("R1 m0 e32", 1, 2'd2, 0, 1, 16'hFFFF,
         128'h0001_0000_FFFF_0000_0000_1000_1234_5678,
         128'h0000_0005_FFFF_FFF0_0000_0001_0000_0000, 32'h0001_0002, 0);
      op("R5 m1 code3", 1, 2'd3, 1, 0, 16'hFFFF,
         128'h0001_0000_FFFF_0000_0000_1000_1234_5678,
         128'h0000_0005_FFFF_FFF0_0000_0001_0000_0000, 32'hFFFF_FFFE, 0);
      // R2 R9: positive saturation in every 8-bit lane
      op("R2 sat pos", 1, 2'd0, 1, 0, 16'hFFFF,
         {16{8'h80}}, {16{8'h80}}, 32'h0000_007F, 0);
      // R10: clear and re-check, then clear together with saturation
      op("R10 clear", 0, 2'd0, 0, 0, 16'h0000, '0, '0, '0, 1);
      op("R2 sat neg", 1, 2'd0, 0, 0, 16'hFFFF,
         {16{8'h80}}, {16{8'h80}}, 32'h0000_007F, 0);
      op("R10 clr+sat", 1, 2'd0, 0, 0, 16'hFFFF,
         {16{8'h80}}, {16{8'h80}}, 32'h0000_007F, 1);
      op("R10 clear2", 0, 2'd0, 0, 0, 16'h0000, '0, '0, '0, 1);
      // R7: partial byte mask on 16-bit lanes (half lanes)
      op("R7 partial", 1, 2'd1, 0, 0, 16'b0110_0001_1000_0011,
         128'h7FFF_1234_0042_8001_0101_0202_7F00_00FF,
         128'h0001_0002_0003_0004_0005_0006_0007_0008, 32'h0000_0101, 0);
      // R9: saturating data fully masked leaves flag and result alone
      op("R9 masked sat", 1, 2'd0, 1, 0, 16'h0000,
         {16{8'h80}}, {16{8'h80}}, 32'h0000_007F, 0);
      // R9: saturation only in a masked lane, unmasked lane fine
      op("R9 lane mask", 1, 2'd0, 1, 0, 16'h0001,
         {{15{8'h80}}, 8'h02}, {{15{8'h80}}, 8'h03}, 32'h0000_007F, 0);
      // R8: idle cycles
      op("R8 idle", 0, 2'd2, 1, 1, 16'hFFFF, '1, '1, '1, 0);
      op("R8 idle2", 0, 2'd0, 0, 0, 16'hFFFF, '0, '1, '0, 0);

      // random sweep across all codes and modes
      for (int n = 0; n < 200; n++) begin
         logic [127:0] ra, rb;
         ra = {$urandom, $urandom, $urandom, $urandom};
         rb = {$urandom, $urandom, $urandom, $urandom};
         op("R1 random", 1'($urandom), 2'($urandom), 1'($urandom), 1'($urandom),
            16'($urandom | ((n % 3 == 0) ? 32'hFFFF : 32'h0)),
            ra, rb, $urandom, 1'((n % 7) == 0));
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule